// File: doc/BRIEF.md
# Synchronous DRAM Bank Burst Data Path

This block is the device-side data path of one bank of a synchronous graphics DRAM. It takes the command pins (chip select, row strobe, column strobe, write enable; all active low), a column address and a write data word on every clock edge. It runs read and write bursts over a small column array that it contains, and it honours a burst-stop command.

A read burst goes through a latency pipeline, so the read data appears one, two or three cycles after each internal column access. The write enable, address and data toward the array are brought out as ports so the write side can be observed. A burst stop ends the access stream at once. Read data already in the latency pipeline still drains, so the output keeps going for as many cycles as the latency. Write data offered on the stop edge or later is dropped.

Top module: `sgram_burst_dp`

## Requirements
- R1: With `cs_n` low and `ras_n` high, `{cas_n,we_n}` selects the command: 2'b01 READ, 2'b00 WRITE, 2'b10 burst stop, 2'b11 no operation. All inputs are sampled on the rising clock edge.
- R2: With `cs_n` high, all other command inputs, the address and the data are ignored. The block behaves as for a no operation, and a running burst continues unchanged.
- R3: With `cs_n` low and `ras_n` low, the command has no effect on this block: no write, and a running burst continues.
- R4: `cas_lat` sets the read latency L (2'd1, 2'd2, 2'd3; 2'd0 acts as 1). For a READ sampled at edge E0, beat k is on `rdata` with `rvalid` high in the cycle that follows edge E(k+L).
- R5: `bl_sel` picks the burst length at the READ or WRITE edge: 3'd0=1, 3'd1=2, 3'd2=4, 3'd3=8, 3'd4..3'd7 = full page (2**COL_W). A fixed-length burst makes exactly that many beats and then stops without any command.
- R6: Beat k of a burst that starts at column S with length N uses column `(S & ~(N-1)) | ((S+k) & (N-1))`. A full-page burst wraps over the whole page and keeps going until it is stopped or replaced.
- R7: A burst stop sampled at edge Es during a read burst prevents every later beat. `rvalid` stays high for exactly L cycles after Es and then goes low.
- R8: The first word of a WRITE is written at the WRITE edge to `col_addr`, using `wdata` from that same edge. Beat k is written at the k-th following edge with the `wdata` sampled there.
- R9: During a write burst, no word is written on the burst-stop edge or on any later edge of that burst.
- R10: A READ or WRITE sampled during a burst cuts the running burst short and starts the new burst from its own address at that edge.
- R11: `rvalid` is high only in cycles that carry read data, and `rdata` is all zeros whenever `rvalid` is low.
- R12: While reset is asserted, `arr_we` and `rvalid` are low, whatever the command inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_addr | input | COL_W | Start column for READ/WRITE |
| wdata | input | DATA_W | Write data word |
| cas_lat | input | 2 | Read latency select |
| bl_sel | input | 3 | Burst length select |
| rdata | output | DATA_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | COL_W | Array write column |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The column state and the beat counter cannot be seen directly. A wrong column shows up as wrong read data on the first affected beat, L cycles after the access. It also shows up as a wrong `arr_addr` in the same cycle as a write beat. A wrong counter or stop handling shows up as `rvalid` running one cycle too long or too short, or as `arr_we` pulsing on a stop edge. Each check therefore compares `rvalid`, `rdata` and the write strobe cycle by cycle against a shadow array. The bench also counts valid beats per burst, so an off-by-one in length or drain time fails at once.

// File: rtl/sgram_dp_pkg.sv
package sgram_dp_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_RD   = 2'd1,
    MODE_WR   = 2'd2
  } mode_e;

  // Pin pattern to internal command; deselect and row commands fold to NOP (R1..R3)
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    c = CMD_NOP;
    if (!cs_n && ras_n) begin
      case ({cas_n, we_n})
        2'b01:   c = CMD_READ;
        2'b00:   c = CMD_WRITE;
        2'b10:   c = CMD_STOP;
        default: c = CMD_NOP;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sgram_cmd_decode.sv
module sgram_cmd_decode
  import sgram_dp_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
  end

endmodule

// File: rtl/sgram_burst_ctrl.sv
module sgram_burst_ctrl
  import sgram_dp_pkg::*;
#(
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [COL_W-1:0] col_addr,
  input  logic [2:0]       bl_sel,
  output logic             rd_fire,
  output logic [COL_W-1:0] rd_col,
  output logic             wr_fire,
  output logic [COL_W-1:0] wr_col
);

  localparam int CNT_W = COL_W + 1;
  localparam logic [CNT_W-1:0] PAGE_LEN = CNT_W'(1 << COL_W);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  mode_e            mode_q, mode_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             page_q, page_d;
  logic             st_en;

  logic [CNT_W-1:0] new_len;
  logic [COL_W-1:0] new_mask;
  logic             new_page;

  function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c,
                                                input logic [COL_W-1:0] m);
    return (c & ~m) | ((c + COL_W'(1)) & m);
  endfunction

  // burst length select
  always_comb begin
    new_page = 1'b0;
    case (bl_sel)
      3'd0:    begin new_len = CNT_W'(1); new_mask = '0;          end
      3'd1:    begin new_len = CNT_W'(2); new_mask = COL_W'(1);   end
      3'd2:    begin new_len = CNT_W'(4); new_mask = COL_W'(3);   end
      3'd3:    begin new_len = CNT_W'(8); new_mask = COL_W'(7);   end
      default: begin new_len = PAGE_LEN;  new_mask = '1; new_page = 1'b1; end
    endcase
  end

  // next state
  always_comb begin
    mode_d = mode_q;
    col_d  = col_q;
    mask_d = mask_q;
    left_d = left_q;
    page_d = page_q;
    st_en  = (cmd != CMD_NOP) || (mode_q != MODE_IDLE);
    case (cmd)
      CMD_READ: begin
        mode_d = MODE_RD;
        col_d  = col_addr;
        mask_d = new_mask;
        left_d = new_len;
        page_d = new_page;
      end
      CMD_WRITE: begin
        mode_d = (new_page || (new_len != ONE)) ? MODE_WR : MODE_IDLE;
        col_d  = step_col(col_addr, new_mask);
        mask_d = new_mask;
        left_d = new_len - ONE;
        page_d = new_page;
      end
      CMD_STOP: begin
        mode_d = MODE_IDLE;
      end
      default: begin
        if (mode_q != MODE_IDLE) begin
          col_d = step_col(col_q, mask_q);
          if (!page_q) begin
            left_d = left_q - ONE;
            if (left_q == ONE) mode_d = MODE_IDLE;
          end
        end
      end
    endcase
  end

  // state registers with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      col_q  <= '0;
      mask_q <= '0;
      left_q <= '0;
      page_q <= 1'b0;
    end else if (st_en) begin
      mode_q <= mode_d;
      col_q  <= col_d;
      mask_q <= mask_d;
      left_q <= left_d;
      page_q <= page_d;
    end
  end

  // beat outputs: read beats run from state, write beat 0 rides the command edge
  assign rd_fire = (mode_q == MODE_RD);
  assign rd_col  = col_q;
  assign wr_fire = (cmd == CMD_WRITE) || ((mode_q == MODE_WR) && (cmd == CMD_NOP));
  assign wr_col  = (cmd == CMD_WRITE) ? col_addr : col_q;

  a_r9_stop_masks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP) |-> !wr_fire);

  a_r7_stop_halts_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP) |=> !rd_fire);

  a_r10_read_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ) |=> (rd_fire && (rd_col == $past(col_addr))));

  a_r5_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q != MODE_IDLE) && !page_q) |-> (left_q != '0));

  a_r6_window_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q != MODE_IDLE) && ($past(mode_q) == mode_q) && ($past(cmd) == CMD_NOP))
      |-> ((col_q & ~mask_q) == ($past(col_q) & ~$past(mask_q))));

endmodule

// File: rtl/sgram_lat_pipe.sv
module sgram_lat_pipe #(
  parameter int DATA_W  = 32,
  parameter int MAX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_in,
  input  logic [DATA_W-1:0] beat_data,
  input  logic [1:0]        lat_sel,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  localparam int IDX_W = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

  logic [MAX_LAT-1:0]             v_q;
  logic [MAX_LAT-1:0]             v_in;
  logic [MAX_LAT-1:0][DATA_W-1:0] d_q;
  logic [MAX_LAT-1:0][DATA_W-1:0] d_in;
  logic [IDX_W-1:0]               lat_idx;

  for (genvar g = 0; g < MAX_LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign v_in[g] = beat_in;
      assign d_in[g] = beat_data;
    end else begin : g_tail
      assign v_in[g] = v_q[g-1];
      assign d_in[g] = d_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      v_q <= v_in;
    end
  end

  // data stages load only behind a valid beat
  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_LAT; i++) begin
      if (v_in[i]) d_q[i] <= d_in[i];
    end
  end

  always_comb begin
    lat_idx = '0;
    for (int i = 0; i < MAX_LAT; i++) begin
      if (int'(lat_sel) == i + 1) lat_idx = IDX_W'(i);
    end
  end

  assign rvalid = v_q[lat_idx];
  assign rdata  = rvalid ? d_q[lat_idx] : '0;

  a_r4_lat_one: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_sel == 2'd1) && beat_in) |=> rvalid);

  a_r4_lat_three: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_sel == 2'd3) && ($past(lat_sel, 3) == 2'd3) && $past(beat_in, 3)) |-> rvalid);

endmodule

// File: rtl/sgram_col_array.sv
module sgram_col_array #(
  parameter int COL_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [COL_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [COL_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sgram_burst_dp.sv
module sgram_burst_dp
  import sgram_dp_pkg::*;
#(
  parameter int COL_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        cas_lat,
  input  logic [2:0]        bl_sel,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              arr_we,
  output logic [COL_W-1:0]  arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);

  localparam int MAX_LAT = 3;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  cmd_e              cmd;
  logic              rd_fire;
  logic [COL_W-1:0]  rd_col;
  logic              wr_fire;
  logic [COL_W-1:0]  wr_col;
  logic [DATA_W-1:0] arr_rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  sgram_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  sgram_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd      (cmd),
    .col_addr (col_addr),
    .bl_sel   (bl_sel),
    .rd_fire  (rd_fire),
    .rd_col   (rd_col),
    .wr_fire  (wr_fire),
    .wr_col   (wr_col)
  );

  assign arr_we    = wr_fire && rst_int_n;
  assign arr_addr  = wr_col;
  assign arr_wdata = wdata;

  sgram_col_array #(.COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_addr),
    .wdata (arr_wdata),
    .raddr (rd_col),
    .rdata (arr_rdata)
  );

  sgram_lat_pipe #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .beat_in   (rd_fire),
    .beat_data (arr_rdata),
    .lat_sel   (cas_lat),
    .rvalid    (rvalid),
    .rdata     (rdata)
  );

endmodule

// File: tb/sgram_burst_dp_tb.sv
module sgram_burst_dp_tb;

  localparam int COL_W  = 6;
  localparam int DATA_W = 32;
  localparam int PAGE   = 1 << COL_W;

  // {cs_n, ras_n, cas_n, we_n}  (R1 encodings)
  localparam logic [3:0] C_NOP    = 4'b0111;
  localparam logic [3:0] C_RD     = 4'b0101;
  localparam logic [3:0] C_WR     = 4'b0100;
  localparam logic [3:0] C_ST     = 4'b0110;
  localparam logic [3:0] C_DES_ST = 4'b1110;
  localparam logic [3:0] C_DES_WR = 4'b1100;
  localparam logic [3:0] C_ROW    = 4'b0011;
  localparam logic [3:0] C_ROWWR  = 4'b0000;

  logic              clk;
  logic              rst_n;
  logic              cs_n, ras_n, cas_n, we_n;
  logic [COL_W-1:0]  col_addr;
  logic [DATA_W-1:0] wdata;
  logic [1:0]        cas_lat;
  logic [2:0]        bl_sel;
  logic [DATA_W-1:0] rdata;
  logic              rvalid;
  logic              arr_we;
  logic [COL_W-1:0]  arr_addr;
  logic [DATA_W-1:0] arr_wdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic              s_rv, s_we;
  logic [DATA_W-1:0] s_rd, s_wd;
  logic [COL_W-1:0]  s_wa;
  logic [DATA_W-1:0] mem_m [PAGE];

  sgram_burst_dp #(.COL_W(COL_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .col_addr(col_addr), .wdata(wdata), .cas_lat(cas_lat), .bl_sel(bl_sel),
    .rdata(rdata), .rvalid(rvalid), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
    end
  endtask

  function automatic logic [COL_W-1:0] exp_mask(input logic [2:0] bs);
    case (bs)
      3'd0: return COL_W'(0);
      3'd1: return COL_W'(1);
      3'd2: return COL_W'(3);
      3'd3: return COL_W'(7);
      default: return '1;
    endcase
  endfunction

  function automatic int exp_len(input logic [2:0] bs);
    return int'(exp_mask(bs)) + 1;
  endfunction

  // R6 column formula
  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s, input logic [2:0] bs,
                                               input int k);
    logic [COL_W-1:0] m;
    m = exp_mask(bs);
    return (s & ~m) | (COL_W'(int'(s) + k) & m);
  endfunction

  // one cycle: sample registered outputs, drive inputs, sample write path
  task automatic step(input logic [3:0] c, input logic [COL_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    s_rv = rvalid;
    s_rd = rdata;
    {cs_n, ras_n, cas_n, we_n} = c;
    col_addr = a;
    wdata    = d;
    #1;
    s_we = arr_we;
    s_wa = arr_addr;
    s_wd = arr_wdata;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cas_lat = 2'd1;
    bl_sel = 3'd0;
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    col_addr = '0;
    wdata = '0;
    for (int i = 0; i < 3; i++) begin
      step(C_WR, COL_W'(i), 32'hDEAD0000);
      chk("R12 we in reset", 64'(s_we), 64'd0);
      chk("R12 rvalid in reset", 64'(s_rv), 64'd0);
    end
    step(C_NOP, '0, '0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(C_NOP, '0, '0);
    chk("R11 rvalid after reset", 64'(rvalid), 64'd0);
  endtask

  // write burst; stop_at==0 means no stop
  task automatic t_write(input logic [COL_W-1:0] s, input logic [2:0] bs, input int stop_at,
                         input logic [DATA_W-1:0] seed);
    int nb;
    logic [DATA_W-1:0] d;
    logic [COL_W-1:0] ec;
    bl_sel = bs;
    nb = exp_len(bs);
    if (stop_at != 0 && stop_at < nb) nb = stop_at;
    for (int t = 0; t <= nb + 1; t++) begin
      d = seed + DATA_W'(t) * 32'h0001_0003;
      if (t == 0) step(C_WR, s, d);
      else if (stop_at != 0 && t == stop_at) step(C_ST, s, d);
      else step(C_NOP, ~s, d);
      if (t < nb) begin
        ec = exp_col(s, bs, t);
        chk($sformatf("R8 we t=%0d", t), 64'(s_we), 64'd1);
        chk($sformatf("R6 waddr t=%0d", t), 64'(s_wa), 64'(ec));
        chk($sformatf("R8 wdata t=%0d", t), 64'(s_wd), 64'(d));
        mem_m[ec] = d;
      end else if (stop_at != 0 && t >= stop_at) begin
        chk($sformatf("R9 no write t=%0d", t), 64'(s_we), 64'd0);
      end else begin
        chk($sformatf("R5 write ended t=%0d", t), 64'(s_we), 64'd0);
      end
    end
  endtask

  // read burst with optional stop and one injected command
  task automatic t_read(input logic [COL_W-1:0] s, input logic [2:0] bs, input logic [1:0] cl,
                        input int stop_at, input int inj_at, input logic [3:0] inj_c,
                        input string tag);
    int nb, lat, nv, k;
    bit ev;
    cas_lat = cl;
    bl_sel  = bs;
    lat = (cl == 2'd0) ? 1 : int'(cl);
    nb = exp_len(bs);
    if (stop_at != 0 && stop_at < nb) nb = stop_at;
    nv = 0;
    for (int t = 0; t <= nb + lat + 3; t++) begin
      if (t == 0) step(C_RD, s, '0);
      else if (stop_at != 0 && t == stop_at) step(C_ST, ~s, '0);
      else if (inj_at != 0 && t == inj_at) step(inj_c, s ^ COL_W'(5), 32'hBAD0_BAD0);
      else step(C_NOP, ~s, '0);
      if (inj_at != 0 && t == inj_at)
        chk({tag, " ignored cmd no write"}, 64'(s_we), 64'd0);
      k  = t - lat - 1;
      ev = (k >= 0) && (k < nb);
      chk($sformatf("%s rvalid t=%0d", tag, t), 64'(s_rv), 64'(ev));
      if (ev) begin
        nv++;
        chk($sformatf("%s R6 data k=%0d", tag, k), 64'(s_rd), 64'(mem_m[exp_col(s, bs, k)]));
      end else begin
        chk($sformatf("%s R11 idle zero t=%0d", tag, t), 64'(s_rd), 64'd0);
      end
    end
    chk({tag, " beat count"}, 64'(nv), 64'(nb));
  endtask

  // R10: READ during a READ burst
  task automatic t_read_restart(input logic [COL_W-1:0] a1, input logic [COL_W-1:0] a2,
                                input logic [1:0] cl);
    int k;
    logic [DATA_W-1:0] e;
    bit ev;
    cas_lat = cl;
    bl_sel  = 3'd3;
    for (int t = 0; t <= 3 + 8 + int'(cl) + 3; t++) begin
      if (t == 0) step(C_RD, a1, '0);
      else if (t == 3) step(C_RD, a2, '0);
      else step(C_NOP, '0, '0);
      ev = 1'b0;
      e  = '0;
      k  = t - int'(cl) - 1;
      if (k >= 0 && k < 3) begin ev = 1'b1; e = mem_m[exp_col(a1, 3'd3, k)]; end
      k  = t - int'(cl) - 4;
      if (k >= 0 && k < 8) begin ev = 1'b1; e = mem_m[exp_col(a2, 3'd3, k)]; end
      chk($sformatf("R10 rd restart rvalid t=%0d", t), 64'(s_rv), 64'(ev));
      chk($sformatf("R10 rd restart data t=%0d", t), 64'(s_rd), 64'(e));
    end
  endtask

  // R10: WRITE during a WRITE burst
  task automatic t_write_restart(input logic [COL_W-1:0] a1, input logic [COL_W-1:0] a2);
    logic [DATA_W-1:0] d;
    logic [COL_W-1:0] ec;
    bl_sel = 3'd3;
    for (int t = 0; t < 8; t++) begin
      d = 32'h7700_0000 + DATA_W'(t);
      if (t == 0) step(C_WR, a1, d);
      else if (t == 2) begin bl_sel = 3'd2; step(C_WR, a2, d); end
      else step(C_NOP, '0, d);
      if (t < 2) begin
        ec = exp_col(a1, 3'd3, t);
        chk($sformatf("R10 wr first t=%0d", t), 64'({s_we, s_wa}), 64'({1'b1, ec}));
        mem_m[ec] = d;
      end else if (t < 6) begin
        ec = exp_col(a2, 3'd2, t - 2);
        chk($sformatf("R10 wr second t=%0d", t), 64'({s_we, s_wa}), 64'({1'b1, ec}));
        mem_m[ec] = d;
      end else begin
        chk($sformatf("R10 wr ended t=%0d", t), 64'(s_we), 64'd0);
      end
    end
  endtask

  // R2/R3 while idle: nothing written, nothing read
  task automatic t_idle_ignore();
    step(C_DES_WR, COL_W'(5), 32'hFFFF_0001);
    chk("R2 deselect write pattern", 64'(s_we), 64'd0);
    step(C_ROWWR, COL_W'(6), 32'hFFFF_0002);
    chk("R3 row-low write pattern", 64'(s_we), 64'd0);
    step(C_DES_ST, COL_W'(7), 32'hFFFF_0003);
    step(C_NOP, '0, '0);
    step(C_NOP, '0, '0);
    chk("R2 no read started", 64'(s_rv), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write('0, 3'd4, PAGE, 32'hA500_0000);          // full page fill, R9 stop at end
    for (int c = 1; c <= 3; c++) begin
      t_read(COL_W'(6), 3'd2, 2'(c), 0, 0, C_NOP, $sformatf("R4 bl4 cl%0d", c));
      t_read(COL_W'(60), 3'd4, 2'(c), 6, 0, C_NOP, $sformatf("R7 page stop cl%0d", c));
    end
    t_read(COL_W'(13), 3'd3, 2'd2, 0, 0, C_NOP, "R6 bl8 wrap");
    t_read(COL_W'(0), 3'd0, 2'd1, 0, 0, C_NOP, "R5 bl1");
    t_read(COL_W'(63), 3'd1, 2'd3, 0, 0, C_NOP, "R5 bl2");
    t_read(COL_W'(9), 3'd3, 2'd0, 0, 0, C_NOP, "R4 cl0 as 1");
    t_read(COL_W'(20), 3'd4, 2'd2, 7, 3, C_DES_ST, "R2 deselect stop");
    t_read(COL_W'(30), 3'd3, 2'd3, 0, 2, C_ROW, "R3 row cmd");
    t_read(COL_W'(2), 3'd3, 2'd1, 3, 0, C_NOP, "R7 bl8 stop");
    t_write(COL_W'(40), 3'd3, 3, 32'h5A00_0000);
    t_read(COL_W'(40), 3'd3, 2'd1, 0, 0, C_NOP, "R9 readback");
    t_write(COL_W'(9), 3'd1, 0, 32'h3300_0000);
    t_read(COL_W'(8), 3'd1, 2'd2, 0, 0, C_NOP, "R8 bl2 readback");
    t_write_restart(COL_W'(50), COL_W'(17));
    t_read_restart(COL_W'(4), COL_W'(45), 2'd2);
    t_idle_ignore();
    t_read('0, 3'd4, 2'd1, PAGE, 0, C_NOP, "R6 page readback");
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule